// File: doc/BRIEF.md
# Sprite Serializer and Priority Compositor

This block sits on the pixel path of a display engine. It holds eight sprite channels. Each channel has a horizontal start, an attach flag and two 16-bit data planes. A 9-bit beam counter advances by one every clock. When an armed channel's start equals the counter, the channel loads its planes into shift registers. It then emits one 2-bit pixel per clock, sixteen in all, most significant bit first.

Channels are grouped in even/odd pairs, and each pair shares three palette slots. An odd channel can be attached to its even partner. The two then act as one sprite whose 4-bit index spans palette slots 16 to 31. The compositor keeps the front-most non-transparent result, where lower channel numbers are in front. The result leaves the block as a registered 5-bit palette index, or as a "none" flag so that the playfield shows through.

Writes to a channel's position take effect at the channel's next start match. Software can therefore show one channel at several horizontal positions on the same line by rewriting its position between matches.

Top module: `sprite_compositor`

## Requirements
- R1: After a synchronous active-low reset, every channel is disarmed and the output shows pix_none=1 with pix_index=0.
- R2: Register select on wr_reg: 0 = position (wr_data[7:0] is start bits 8:1), 1 = control (wr_data[1] is start bit 0, wr_data[0] is attach), 2 = plane A, 3 = plane B. A control write disarms the channel. A plane A write arms it.
- R3: An armed channel matches when hpos equals its 9-bit start. It then produces 16 consecutive pixels, MSB first, one per clock. The pixel for beam value H appears on the outputs one clock after hpos=H is sampled.
- R4: A single sprite's pixel value is {plane B bit, plane A bit}, and 00 is transparent.
- R5: A visible single-sprite pixel of value v from pair p (channels 2p, 2p+1) gives pix_index = 16 + 4p + v. Pair 0 therefore uses 17–19, pair 1 uses 21–23, pair 2 uses 25–27 and pair 3 uses 29–31.
- R6: When the odd channel of a pair has attach=1, the pair gives 4-bit value {odd pixel, even pixel} and pix_index = 16 + that value. A value of 0000 is transparent, and the odd channel is never shown on its own.
- R7: When several channels are opaque on the same pixel, the lowest-numbered channel wins. Within an unattached pair, the even channel wins over the odd one.
- R8: A position write made while the line is in progress is used at the channel's next match. The same channel can therefore be drawn again further right on that line.
- R9: A channel disarmed by a control write produces no pixels, even when hpos equals its start.
- R10: When no channel is opaque, pix_none=1 and pix_index=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | 3 | Channel number of the write |
| wr_reg | input | 2 | Register select (position, control, plane A, plane B) |
| wr_data | input | 16 | Write data |
| hpos | input | 9 | Horizontal beam counter, advancing one per clock |
| pix_index | output | 5 | Registered palette index of the winning sprite pixel |
| pix_none | output | 1 | Registered flag: no sprite is opaque at this pixel |

## Verification
Two functions can land in the same cycle.

The first pair is a channel's serialization and another channel's output on the same pixel. This is provoked by placing channel 0 and channel 5 so that they overlap, and by placing an attached pair next to an unattached one. The result is judged pixel by pixel against an expected index. That index is worked out from the priority and attach rules.

The second pair is a register write and an active line. The test rewrites a channel's position in the middle of the sweep, and in another case disarms a channel before its start is reached. It then checks that the second copy appears at the new start and that the disarmed channel stays transparent.

// File: rtl/sprite_pkg.sv
// Shared constants and types for the sprite compositor.
// Assumes eight channels in four even/odd pairs, each channel 16 pixels wide.
package sprite_pkg;
    localparam int SPR_NUM  = 8;
    localparam int PLANE_W  = 16;
    localparam int BEAM_W   = 9;
    localparam int PAIR_NUM = SPR_NUM / 2;
    localparam int CHAN_W   = $clog2(SPR_NUM);
    localparam int COL_W    = 4;
    localparam int IDX_W    = COL_W + 1;

    typedef enum logic [1:0] {
        REG_POS  = 2'd0,
        REG_CTL  = 2'd1,
        REG_PLA  = 2'd2,
        REG_PLB  = 2'd3
    } spr_reg_e;
endpackage

// File: rtl/sprite_channel.sv
// One sprite channel: holds the start, attach flag and two data planes, and
// shifts the planes out MSB first for 16 clocks after a start match.
// Assumes hpos advances one step per clock; shifting is clock-paced.
module sprite_channel
    import sprite_pkg::*;
#(
    parameter int DATA_W = PLANE_W,
    parameter int HW     = BEAM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        wreg,
    input  logic [DATA_W-1:0] wdata,
    input  logic [HW-1:0]     hpos,
    output logic [1:0]        pix,
    output logic              attach
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [HW-1:0]     start_q;
    logic [DATA_W-1:0] pla_q, plb_q, sha_q, shb_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              armed_q, attach_q, match;

    assign match  = armed_q && (hpos == start_q);
    assign attach = attach_q;

    // Register file writes: position, control (disarms), planes (A arms).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= '0;
            attach_q <= 1'b0;
            pla_q    <= '0;
            plb_q    <= '0;
            armed_q  <= 1'b0;
        end else if (we) begin
            case (spr_reg_e'(wreg))
                REG_POS: start_q[HW-1:1] <= wdata[HW-2:0];
                REG_CTL: begin
                    start_q[0] <= wdata[1];
                    attach_q   <= wdata[0];
                    armed_q    <= 1'b0;
                end
                REG_PLA: begin
                    pla_q   <= wdata;
                    armed_q <= 1'b1;
                end
                default: plb_q <= wdata;
            endcase
        end
    end

    // Serializer: load on match, otherwise shift while pixels remain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sha_q <= '0;
            shb_q <= '0;
            cnt_q <= '0;
        end else if (match) begin
            sha_q <= pla_q << 1;
            shb_q <= plb_q << 1;
            cnt_q <= LAST;
        end else if (cnt_q != '0) begin
            sha_q <= sha_q << 1;
            shb_q <= shb_q << 1;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Current pixel: first bit straight from the latches, then from shifters.
    always_comb begin
        if (match)             pix = {plb_q[DATA_W-1], pla_q[DATA_W-1]};
        else if (cnt_q != '0)  pix = {shb_q[DATA_W-1], sha_q[DATA_W-1]};
        else                   pix = 2'b00;
    end

    a_r2_ctl_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wreg == REG_CTL) |=> !armed_q);
    a_r2_pla_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wreg == REG_PLA) |=> armed_q);
    a_r3_load_full: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (cnt_q == LAST));
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    a_r9_idle_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && cnt_q == '0) |-> (pix == 2'b00));
endmodule

// File: rtl/sprite_pair_merge.sv
// Combines the two pixels of an even/odd pair into one 4-bit palette offset.
// Attached: {odd, even}. Unattached: {pair number, even pixel, or else odd pixel}.
// Assumes four pairs, so the pair number fits in two bits.
module sprite_pair_merge
    import sprite_pkg::*;
#(
    parameter int PAIR_ID = 0
) (
    input  logic [1:0]       pix_even,
    input  logic [1:0]       pix_odd,
    input  logic             attach_odd,
    output logic             vis,
    output logic [COL_W-1:0] col
);
    localparam logic [1:0] PID = 2'(PAIR_ID);

    // Select the pair's offset: attached merge, or even before odd.
    always_comb begin
        if (attach_odd) begin
            col = {pix_odd, pix_even};
            vis = (col != '0);
        end else if (pix_even != 2'b00) begin
            col = {PID, pix_even};
            vis = 1'b1;
        end else begin
            col = {PID, pix_odd};
            vis = (pix_odd != 2'b00);
        end
    end
endmodule

// File: rtl/sprite_prio.sv
// Fixed-priority selector over pairs: the lowest visible pair wins.
module sprite_prio
    import sprite_pkg::*;
#(
    parameter int NP = PAIR_NUM
) (
    input  logic [NP-1:0]             vis,
    input  logic [NP-1:0][COL_W-1:0]  col,
    output logic                      win_vis,
    output logic [COL_W-1:0]          win_col
);
    // Scan from the back pair forward so the front pair overrides.
    always_comb begin
        win_vis = 1'b0;
        win_col = '0;
        for (int p = NP - 1; p >= 0; p--) begin
            if (vis[p]) begin
                win_vis = 1'b1;
                win_col = col[p];
            end
        end
    end
endmodule

// File: rtl/sprite_compositor.sv
// Top: eight sprite channels, pair merge, priority pick, registered output.
// Assumes hpos advances one per clock. The output lags hpos by one clock.
module sprite_compositor
    import sprite_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CHAN_W-1:0]   wr_chan,
    input  logic [1:0]          wr_reg,
    input  logic [PLANE_W-1:0]  wr_data,
    input  logic [BEAM_W-1:0]   hpos,
    output logic [IDX_W-1:0]    pix_index,
    output logic                pix_none
);
    logic [SPR_NUM-1:0][1:0]        ch_pix;
    logic [SPR_NUM-1:0]             ch_att;
    logic [PAIR_NUM-1:0]            pr_vis;
    logic [PAIR_NUM-1:0][COL_W-1:0] pr_col;
    logic                           win_vis;
    logic [COL_W-1:0]               win_col;

    for (genvar c = 0; c < SPR_NUM; c++) begin : g_ch
        sprite_channel #(.DATA_W(PLANE_W), .HW(BEAM_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (wr_en && (wr_chan == CHAN_W'(c))),
            .wreg   (wr_reg),
            .wdata  (wr_data),
            .hpos   (hpos),
            .pix    (ch_pix[c]),
            .attach (ch_att[c])
        );
    end

    for (genvar p = 0; p < PAIR_NUM; p++) begin : g_pair
        sprite_pair_merge #(.PAIR_ID(p)) u_merge (
            .pix_even   (ch_pix[2*p]),
            .pix_odd    (ch_pix[2*p+1]),
            .attach_odd (ch_att[2*p+1]),
            .vis        (pr_vis[p]),
            .col        (pr_col[p])
        );
    end

    sprite_prio #(.NP(PAIR_NUM)) u_prio (
        .vis     (pr_vis),
        .col     (pr_col),
        .win_vis (win_vis),
        .win_col (win_col)
    );

    // Output register: palette slot 16+offset, or the none flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_index <= '0;
            pix_none  <= 1'b1;
        end else begin
            pix_index <= win_vis ? {1'b1, win_col} : '0;
            pix_none  <= !win_vis;
        end
    end

    a_r10_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pix_none |-> (pix_index == '0));
    a_r5_upper_bank: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_none |-> pix_index[IDX_W-1]);
    a_r7_front_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_vis[0] && !ch_att[1]) |=> (pix_index[3:2] == 2'b00));
endmodule

// File: tb/sprite_compositor_tb.sv
module sprite_compositor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_chan = '0;
    logic [1:0]  wr_reg = '0;
    logic [15:0] wr_data = '0;
    logic [8:0]  hpos = 9'h1FF;
    logic [4:0]  pix_index;
    logic        pix_none;

    always #5 clk = ~clk;

    sprite_compositor u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_reg(wr_reg), .wr_data(wr_data), .hpos(hpos),
        .pix_index(pix_index), .pix_none(pix_none)
    );

    typedef struct {
        int         due;
        logic       none;
        logic [4:0] idx;
        string      req;
    } exp_t;

    exp_t  sb_q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R3";

    // Bench-side model state, built from the requirements.
    logic [8:0]  m_start [8];
    logic        m_att   [8];
    logic        m_arm   [8];
    logic [15:0] m_pla   [8];
    logic [15:0] m_plb   [8];
    logic [15:0] m_sa    [8];
    logic [15:0] m_sb    [8];
    int          m_k     [8];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop expected items as they fall due and compare.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (pix_none !== e.none || pix_index !== e.idx) begin
                n_fail++;
                $display("FAIL %s: got none=%0b idx=%0d, expected none=%0b idx=%0d",
                         e.req, pix_none, pix_index, e.none, e.idx);
            end
        end
    end

    // Driver: one clock of stimulus; pushes the expected output for it.
    task automatic step(input logic [8:0] h, input logic we, input logic [2:0] ch,
                        input logic [1:0] rg, input logic [15:0] d);
        logic [1:0] px [8];
        logic       vis;
        logic [3:0] col;
        exp_t       e;
        @(negedge clk);
        hpos = h; wr_en = we; wr_chan = ch; wr_reg = rg; wr_data = d;
        for (int c = 0; c < 8; c++) begin
            if (m_arm[c] && h == m_start[c]) begin
                m_sa[c] = m_pla[c];
                m_sb[c] = m_plb[c];
                m_k[c]  = 0;
            end
            if (m_k[c] < 16) begin
                px[c] = {m_sb[c][15 - m_k[c]], m_sa[c][15 - m_k[c]]};
                m_k[c]++;
            end else begin
                px[c] = 2'b00;
            end
        end
        vis = 1'b0;
        col = '0;
        for (int p = 3; p >= 0; p--) begin
            if (m_att[2*p+1]) begin
                if ({px[2*p+1], px[2*p]} != 4'd0) begin
                    vis = 1'b1; col = {px[2*p+1], px[2*p]};
                end
            end else if (px[2*p] != 2'b00) begin
                vis = 1'b1; col = {2'(p), px[2*p]};
            end else if (px[2*p+1] != 2'b00) begin
                vis = 1'b1; col = {2'(p), px[2*p+1]};
            end
        end
        e.due  = cyc + 1;
        e.none = !vis;
        e.idx  = vis ? {1'b1, col} : 5'd0;
        e.req  = cur_req;
        sb_q.push_back(e);
        if (we) begin
            case (rg)
                2'd0: m_start[ch][8:1] = d[7:0];
                2'd1: begin m_start[ch][0] = d[1]; m_att[ch] = d[0]; m_arm[ch] = 1'b0; end
                2'd2: begin m_pla[ch] = d; m_arm[ch] = 1'b1; end
                default: m_plb[ch] = d;
            endcase
        end
    endtask

    task automatic wr(input logic [2:0] ch, input logic [1:0] rg, input logic [15:0] d);
        step(9'h1FF, 1'b1, ch, rg, d);
    endtask

    task automatic set_spr(input logic [2:0] ch, input logic [8:0] st, input logic att,
                           input logic [15:0] a, input logic [15:0] b);
        wr(ch, 2'd0, {8'h00, st[8:1]});
        wr(ch, 2'd1, {14'h0, st[0], att});
        wr(ch, 2'd3, b);
        wr(ch, 2'd2, a);
    endtask

    task automatic disarm_all();
        for (int c = 0; c < 8; c++) wr(3'(c), 2'd1, 16'h0000);
    endtask

    task automatic sweep(input int lo, input int hi);
        for (int h = lo; h <= hi; h++) step(9'(h), 1'b0, 3'd0, 2'd0, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 8; c++) begin
            m_start[c] = '0; m_att[c] = 1'b0; m_arm[c] = 1'b0;
            m_pla[c] = '0; m_plb[c] = '0; m_sa[c] = '0; m_sb[c] = '0; m_k[c] = 16;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports.
        n_chk++;
        if (pix_none !== 1'b1 || pix_index !== 5'd0) begin
            n_fail++;
            $display("FAIL R1: got none=%0b idx=%0d, expected none=1 idx=0", pix_none, pix_index);
        end
        rst_n = 1'b1;
        cur_req = "R1/R10";
        sweep(0, 20);

        // R3 R4 R5: single sprite on pair 1, all four pixel values.
        cur_req = "R3/R4/R5";
        set_spr(3'd2, 9'd40, 1'b0, 16'b1010_0110_1100_0011, 16'b0110_1010_0011_1100);
        sweep(30, 70);

        // R2: odd start via control bit 1, odd channel of pair 3.
        cur_req = "R2";
        disarm_all();
        set_spr(3'd7, 9'd33, 1'b0, 16'hF00F, 16'h0FF0);
        sweep(25, 60);

        // R7: channel 0 overlaps channel 5; also channel 1 behind channel 0.
        cur_req = "R7";
        disarm_all();
        set_spr(3'd0, 9'd40, 1'b0, 16'hF0F0, 16'h0000);
        set_spr(3'd5, 9'd44, 1'b0, 16'hFFFF, 16'hFFFF);
        set_spr(3'd1, 9'd42, 1'b0, 16'hFFFF, 16'h0000);
        sweep(35, 70);

        // R6: attached pair 6/7 beside unattached pair 2.
        cur_req = "R6";
        disarm_all();
        set_spr(3'd6, 9'd70, 1'b0, 16'hA5A5, 16'h3C3C);
        set_spr(3'd7, 9'd70, 1'b1, 16'h0F0F, 16'hFF00);
        set_spr(3'd4, 9'd80, 1'b0, 16'h00FF, 16'h0F0F);
        sweep(65, 100);

        // R6: attached with the odd half alone non-zero is shown merged.
        set_spr(3'd6, 9'd120, 1'b0, 16'h0000, 16'h0000);
        set_spr(3'd7, 9'd120, 1'b1, 16'hFFFF, 16'h00FF);
        sweep(115, 140);

        // R8: reposition channel 3 mid-line, second copy on the same line.
        cur_req = "R8";
        disarm_all();
        set_spr(3'd3, 9'd10, 1'b0, 16'hFFFF, 16'hAAAA);
        sweep(0, 30);
        step(9'd31, 1'b1, 3'd3, 2'd0, 16'h001E);
        sweep(32, 90);

        // R9: channel disarmed by a control write before its start.
        cur_req = "R9";
        disarm_all();
        set_spr(3'd4, 9'd20, 1'b0, 16'hFFFF, 16'hFFFF);
        wr(3'd4, 2'd1, 16'h0000);
        sweep(10, 45);

        cur_req = "R10";
        sweep(46, 60);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule